// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Break Input

This block gathers 32 level-sensitive interrupt request lines from on-chip peripherals and presents one interrupt request to the CPU. Each line may stand for several peripheral events ORed together. Software gives every line a 3-bit urgency level. Levels 0 to 6 are active, and 0 is the most urgent. Level 7 switches the line off. Each cycle the block samples the lines into a pending register. From that register it picks the most urgent enabled line, and when two lines share a level the lower index wins. The request goes to the CPU only when the CPU's global enable input is high and the winner's level is numerically below the current mask level.

When the CPU acknowledges a request, the block records the winning index and level on a small service stack. It then raises the mask to that level, so that only strictly more urgent lines can nest on top. When software writes the index of the innermost routine to the end-of-service register, that entry is removed and the mask it replaced comes back. A separate active-low break pin passes through a two-stage synchroniser. A high-to-low transition on it sets a sticky break request that neither the enable input nor the mask can block. Only a dedicated acknowledge strobe clears it.

Top module: `prio_intc`

## Requirements
- R1: After reset every source level reads 7. A level written to register address n (n = 0..31, bits 2:0 of write data) reads back at address n. A pending source whose level is 7 never raises ext_irq.
- R2: Address 33 reads the pending vector, bit n being irq_in[n] as sampled at the previous rising clock edge.
- R3: Among pending enabled sources the one with the numerically lowest level wins, and irq_lvl reports that level.
- R4: When several pending sources share the winning level, the lowest source index wins and irq_id reports it.
- R5: ext_irq is high only when ie was high and the winner's level is below the mask. A source that rises before edge k with ie high and an open mask shows ext_irq after edge k+1. While ext_irq is low, irq_id reads 0 and irq_lvl reads 7.
- R6: An ack sampled while ext_irq is high pushes irq_id and irq_lvl onto the service stack. At the same edge cur_mask becomes that level, and svc_id and svc_lvl show the new entry.
- R7: A write to address 34 whose bits 4:0 equal svc_id pops the innermost entry and restores the mask that was in force before its ack. A write with any other value changes nothing.
- R8: Acks nest up to 8 deep. svc_active is high while the stack is non-empty, and after a pop svc_id shows the next outer entry.
- R9: A high-to-low transition on brk_n sets brk_req after the third rising edge following the change, regardless of ie and cur_mask.
- R10: brk_req stays high until a brk_ack strobe. A level held low or a rising edge on brk_n does not set it again.
- R11: After reset ext_irq, brk_req and svc_active are 0, and cur_mask (also written and read at address 32, bits 2:0) is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 32 | Level-sensitive peripheral requests |
| ie | input | 1 | CPU global interrupt enable |
| brk_n | input | 1 | Active-low asynchronous break pin |
| brk_ack | input | 1 | Clears the sticky break request |
| ack | input | 1 | CPU acknowledge of ext_irq |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ext_irq | output | 1 | Maskable interrupt request to CPU |
| irq_id | output | 5 | Index of the requesting source |
| irq_lvl | output | 3 | Level of the requesting source |
| brk_req | output | 1 | Non-maskable break request |
| cur_mask | output | 3 | Current mask level |
| svc_id | output | 5 | Source index of innermost serviced entry |
| svc_lvl | output | 3 | Level of innermost serviced entry |
| svc_active | output | 1 | Service stack non-empty |

## Verification
The bench sets up ties at one level across distant indices. A design with a reversed scan or a `<=` compare would report the higher index. It checks that a level-7 source stays silent and that a winner whose level equals the mask is held back; an off-by-one mask compare would let it through. It nests two acks and then sends a mismatched end-of-service write followed by matching ones. A design that pops without checking the index, or that restores the wrong mask, would show the wrong svc_id or cur_mask. It also holds the break pin low across an acknowledge. A level-sensitive or unsynchronised break path would either fire again or fire early.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NSRC    = 32;
  localparam int LVLW    = 3;
  localparam int IDW     = $clog2(NSRC);
  localparam int ADDRW   = 6;
  localparam int DATAW   = 32;
  localparam int LVL_OFF = (1 << LVLW) - 1;
  localparam int A_MASK  = NSRC;
  localparam int A_PEND  = NSRC + 1;
  localparam int A_EOS   = NSRC + 2;

  typedef struct packed {
    logic            valid;
    logic [IDW-1:0]  id;
    logic [LVLW-1:0] lvl;
  } win_t;

  // Scan from the top index down, so an equal level found later (lower index) takes over.
  function automatic win_t pick_winner(input logic [NSRC-1:0] pend,
                                       input logic [NSRC*LVLW-1:0] lvls);
    win_t w;
    logic [LVLW-1:0] l;
    w = '{valid: 1'b0, id: '0, lvl: LVLW'(LVL_OFF)};
    for (int i = NSRC - 1; i >= 0; i--) begin
      l = lvls[i*LVLW +: LVLW];
      if (pend[i] && (l != LVLW'(LVL_OFF)) && (!w.valid || l <= w.lvl)) begin
        w.valid = 1'b1;
        w.id    = IDW'(i);
        w.lvl   = l;
      end
    end
    return w;
  endfunction

  function automatic logic below_mask(input logic [LVLW-1:0] lvl, input logic [LVLW-1:0] mask);
    return lvl < mask;
  endfunction
endpackage

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
(
  input  logic [NSRC-1:0]      pend,
  input  logic [NSRC*LVLW-1:0] lvls,
  output logic                 win_valid,
  output logic [IDW-1:0]       win_id,
  output logic [LVLW-1:0]      win_lvl
);
  win_t w;
  always_comb begin
    w         = pick_winner(pend, lvls);
    win_valid = w.valid;
    win_id    = w.id;
    win_lvl   = w.lvl;
  end
endmodule

// File: rtl/intc_brk_detect.sv
module intc_brk_detect #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic brk_n,
  input  logic brk_ack,
  output logic fall,
  output logic brk_req
);
  localparam int TAPS = SYNC + 1;
  logic [TAPS-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[TAPS-2:0], brk_n};
  end

  assign fall = !sh[SYNC-1] && sh[SYNC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       brk_req <= 1'b0;
    else if (fall)    brk_req <= 1'b1;
    else if (brk_ack) brk_req <= 1'b0;
  end
endmodule

// File: rtl/intc_svc_stack.sv
module intc_svc_stack
  import intc_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [IDW-1:0]  push_id,
  input  logic [LVLW-1:0] push_lvl,
  input  logic            pop_req,
  input  logic [IDW-1:0]  pop_id,
  input  logic            mask_we,
  input  logic [LVLW-1:0] mask_wdata,
  output logic            do_push,
  output logic            do_pop,
  output logic [LVLW-1:0] mask_next,
  output logic [LVLW-1:0] mask,
  output logic [IDW-1:0]  top_id,
  output logic [LVLW-1:0] top_lvl,
  output logic            active
);
  localparam int CW  = $clog2(DEPTH + 1);
  localparam int IXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [LVLW-1:0] sv_mask [DEPTH];
  logic [IDW-1:0]  sv_id   [DEPTH];
  logic [LVLW-1:0] sv_lvl  [DEPTH];
  logic [CW-1:0]   cnt;
  logic [IXW-1:0]  top_ix, new_ix;

  assign active  = (cnt != '0);
  assign top_ix  = IXW'(cnt - CW'(1));
  assign new_ix  = IXW'(cnt);
  assign top_id  = active ? sv_id[top_ix]  : '0;
  assign top_lvl = active ? sv_lvl[top_ix] : LVLW'(LVL_OFF);
  assign do_push = push && (cnt < CW'(DEPTH));
  assign do_pop  = !do_push && pop_req && active && (pop_id == sv_id[top_ix]);

  always_comb begin
    if (do_push)      mask_next = push_lvl;
    else if (do_pop)  mask_next = sv_mask[top_ix];
    else if (mask_we) mask_next = mask_wdata;
    else              mask_next = mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      mask <= LVLW'(LVL_OFF);
      for (int i = 0; i < DEPTH; i++) begin
        sv_mask[i] <= '0;
        sv_id[i]   <= '0;
        sv_lvl[i]  <= '0;
      end
    end else begin
      mask <= mask_next;
      if (do_push) begin
        sv_mask[new_ix] <= mask;
        sv_id[new_ix]   <= push_id;
        sv_lvl[new_ix]  <= push_lvl;
        cnt             <= cnt + CW'(1);
      end else if (do_pop) begin
        cnt <= cnt - CW'(1);
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int SYNC  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_in,
  input  logic              ie,
  input  logic              brk_n,
  input  logic              brk_ack,
  input  logic              ack,
  input  logic              reg_we,
  input  logic [ADDRW-1:0]  reg_addr,
  input  logic [DATAW-1:0]  reg_wdata,
  output logic [DATAW-1:0]  reg_rdata,
  output logic              ext_irq,
  output logic [IDW-1:0]    irq_id,
  output logic [LVLW-1:0]   irq_lvl,
  output logic              brk_req,
  output logic [LVLW-1:0]   cur_mask,
  output logic [IDW-1:0]    svc_id,
  output logic [LVLW-1:0]   svc_lvl,
  output logic              svc_active
);
  logic [NSRC-1:0]      pend_q;
  logic [NSRC*LVLW-1:0] lvl_q;
  logic                 win_valid;
  logic [IDW-1:0]       win_id;
  logic [LVLW-1:0]      win_lvl;
  logic                 ext_d;
  logic                 push_ev, pop_ev, brk_fall;
  logic [LVLW-1:0]      mask_next;
  logic                 wr_mask, wr_eos;

  assign wr_mask = reg_we && (reg_addr == ADDRW'(A_MASK));
  assign wr_eos  = reg_we && (reg_addr == ADDRW'(A_EOS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= irq_in;
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_lvl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lvl_q[g*LVLW +: LVLW] <= LVLW'(LVL_OFF);
      else if (reg_we && (reg_addr == ADDRW'(g)))
        lvl_q[g*LVLW +: LVLW] <= reg_wdata[LVLW-1:0];
    end
  end

  intc_arbiter u_arb (
    .pend      (pend_q),
    .lvls      (lvl_q),
    .win_valid (win_valid),
    .win_id    (win_id),
    .win_lvl   (win_lvl)
  );

  intc_svc_stack #(.DEPTH(DEPTH)) u_stk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (ack && ext_irq),
    .push_id    (irq_id),
    .push_lvl   (irq_lvl),
    .pop_req    (wr_eos),
    .pop_id     (reg_wdata[IDW-1:0]),
    .mask_we    (wr_mask),
    .mask_wdata (reg_wdata[LVLW-1:0]),
    .do_push    (push_ev),
    .do_pop     (pop_ev),
    .mask_next  (mask_next),
    .mask       (cur_mask),
    .top_id     (svc_id),
    .top_lvl    (svc_lvl),
    .active     (svc_active)
  );

  intc_brk_detect #(.SYNC(SYNC)) u_brk (
    .clk     (clk),
    .rst_n   (rst_n),
    .brk_n   (brk_n),
    .brk_ack (brk_ack),
    .fall    (brk_fall),
    .brk_req (brk_req)
  );

  assign ext_d = win_valid && ie && below_mask(win_lvl, mask_next);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_irq <= 1'b0;
      irq_id  <= '0;
      irq_lvl <= LVLW'(LVL_OFF);
    end else begin
      ext_irq <= ext_d;
      irq_id  <= ext_d ? win_id  : '0;
      irq_lvl <= ext_d ? win_lvl : LVLW'(LVL_OFF);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < ADDRW'(NSRC))
      reg_rdata[LVLW-1:0] = lvl_q[reg_addr[IDW-1:0]*LVLW +: LVLW];
    else if (reg_addr == ADDRW'(A_MASK))
      reg_rdata[LVLW-1:0] = cur_mask;
    else if (reg_addr == ADDRW'(A_PEND))
      reg_rdata[NSRC-1:0] = pend_q;
  end
endmodule

// File: rtl/intc_checker.sv
module intc_checker
  import intc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            ie,
  input logic            brk_ack,
  input logic            ext_irq,
  input logic [IDW-1:0]  irq_id,
  input logic [LVLW-1:0] irq_lvl,
  input logic [LVLW-1:0] cur_mask,
  input logic [IDW-1:0]  svc_id,
  input logic            svc_active,
  input logic            brk_req,
  input logic            brk_fall,
  input logic            push_ev,
  input logic            pop_ev
);
  assert_off_level_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq |-> irq_lvl != LVLW'(LVL_OFF));

  assert_ext_needs_ie_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ext_irq |-> $past(ie));

  assert_push_latches_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> (cur_mask == $past(irq_lvl)) && (svc_id == $past(irq_id)));

  assert_nest_active_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push_ev |=> svc_active);

  assert_pop_matches_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ev |-> svc_active);

  assert_break_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_fall |=> brk_req);

  assert_break_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !brk_ack) |=> brk_req);
endmodule

bind prio_intc intc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ie         (ie),
  .brk_ack    (brk_ack),
  .ext_irq    (ext_irq),
  .irq_id     (irq_id),
  .irq_lvl    (irq_lvl),
  .cur_mask   (cur_mask),
  .svc_id     (svc_id),
  .svc_active (svc_active),
  .brk_req    (brk_req),
  .brk_fall   (brk_fall),
  .push_ev    (push_ev),
  .pop_ev     (pop_ev)
);

// File: tb/test_prio_intc.sv
`timescale 1ns/1ps
module test_prio_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        ie = 1'b0, brk_n = 1'b1, brk_ack = 1'b0, ack = 1'b0, reg_we = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ext_irq, brk_req, svc_active;
  logic [4:0]  irq_id, svc_id;
  logic [2:0]  irq_lvl, cur_mask, svc_lvl;

  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  prio_intc i_prio_intc (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ie(ie), .brk_n(brk_n),
    .brk_ack(brk_ack), .ack(ack), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_irq(ext_irq),
    .irq_id(irq_id), .irq_lvl(irq_lvl), .brk_req(brk_req), .cur_mask(cur_mask),
    .svc_id(svc_id), .svc_lvl(svc_lvl), .svc_active(svc_active)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  bit [31:0] m_pend;
  int        m_lvl [32];
  int        m_mask, m_id, m_wl;
  bit        m_ext, m_brk;
  bit        h0, h1, h2;
  int        q_mask[$], q_id[$], q_lvl[$];

  always @(posedge clk) begin
    int best, blvl, mnext;
    bit dpush, dpop, ext_n, fell;
    if (!rst_n) begin
      m_pend = '0; m_mask = 7; m_id = 0; m_wl = 7; m_ext = 0; m_brk = 0;
      h0 = 1; h1 = 1; h2 = 1;
      foreach (m_lvl[i]) m_lvl[i] = 7;
      q_mask.delete(); q_id.delete(); q_lvl.delete();
    end else begin
      best = -1; blvl = 7;
      for (int i = 0; i < 32; i++)
        if (m_pend[i] && m_lvl[i] != 7 && (best < 0 || m_lvl[i] < blvl)) begin
          best = i; blvl = m_lvl[i];
        end
      dpush = ack && m_ext && q_id.size() < 8;
      dpop  = !dpush && reg_we && reg_addr == 34 && q_id.size() > 0 &&
              int'(reg_wdata[4:0]) == q_id[q_id.size()-1];
      mnext = m_mask;
      if (dpush) begin
        mnext = m_wl;
        q_mask.push_back(m_mask); q_id.push_back(m_id); q_lvl.push_back(m_wl);
      end else if (dpop) begin
        mnext = q_mask[q_mask.size()-1];
        void'(q_mask.pop_back()); void'(q_id.pop_back()); void'(q_lvl.pop_back());
      end else if (reg_we && reg_addr == 32) mnext = int'(reg_wdata[2:0]);
      ext_n = (best >= 0) && (blvl < mnext) && ie;
      if (reg_we && reg_addr < 32) m_lvl[reg_addr] = int'(reg_wdata[2:0]);
      m_pend = irq_in;
      m_ext  = ext_n;
      m_id   = ext_n ? best : 0;
      m_wl   = ext_n ? blvl : 7;
      m_mask = mnext;
      fell = !h1 && h2;
      if (fell) m_brk = 1; else if (brk_ack) m_brk = 0;
      h2 = h1; h1 = h0; h0 = brk_n;
      #2;
      check("R5 ext_irq model", ext_irq, m_ext);
      check("R3 irq_id model", irq_id, m_id);
      check("R3 irq_lvl model", irq_lvl, m_wl);
      check("R6 cur_mask model", cur_mask, m_mask);
      check("R8 svc_active model", svc_active, q_id.size() > 0);
      check("R8 svc_id model", svc_id, q_id.size() > 0 ? q_id[q_id.size()-1] : 0);
      check("R8 svc_lvl model", svc_lvl, q_lvl.size() > 0 ? q_lvl[q_lvl.size()-1] : 7);
      check("R9 brk_req model", brk_req, m_brk);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    reg_we = 1; reg_addr = 6'(a); reg_wdata = 32'(d);
    tick(1);
    reg_we = 0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic rd(input string tag, input int a, input int exp);
    reg_addr = 6'(a);
    #1;
    check(tag, reg_rdata, exp);
    reg_addr = '0;
  endtask

  task automatic pulse_ack();
    ack = 1; tick(1); ack = 0;
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R11 reset state
    check("R11 ext_irq reset", ext_irq, 0);
    check("R11 cur_mask reset", cur_mask, 7);
    check("R11 brk_req reset", brk_req, 0);
    check("R11 svc_active reset", svc_active, 0);
    rd("R1 level reset", 5, 7);
    rd("R11 mask read", 32, 7);

    ie = 1;
    wr(3, 4); wr(10, 2); wr(20, 2); wr(5, 7);
    rd("R1 level readback", 10, 2);

    irq_in[3] = 1;
    tick(1);
    check("R5 not yet after one edge", ext_irq, 0);
    tick(1);
    check("R5 raised after two edges", ext_irq, 1);
    check("R3 single id", irq_id, 3);
    check("R3 single lvl", irq_lvl, 4);

    irq_in[20] = 1; irq_in[10] = 1;
    tick(2);
    check("R4 tie lowest index", irq_id, 10);
    check("R3 most urgent level", irq_lvl, 2);
    rd("R2 pending readback", 33, 32'h0010_0408);

    irq_in = '0; irq_in[5] = 1;
    tick(2);
    check("R1 disabled source silent", ext_irq, 0);

    irq_in = 32'h0010_0408; ie = 0;
    tick(2);
    check("R5 ie low blocks", ext_irq, 0);
    ie = 1;
    wr(32, 2);
    tick(1);
    check("R5 level equal to mask blocked", ext_irq, 0);
    wr(32, 3);
    check("R5 level below mask passes", ext_irq, 1);
    check("R4 id under mask 3", irq_id, 10);

    pulse_ack();
    check("R6 svc_id latched", svc_id, 10);
    check("R6 svc_lvl latched", svc_lvl, 2);
    check("R6 mask raised", cur_mask, 2);
    check("R8 active after ack", svc_active, 1);

    wr(7, 0);
    irq_in[7] = 1;
    tick(2);
    check("R8 nested request id", irq_id, 7);
    pulse_ack();
    check("R8 nested svc_id", svc_id, 7);
    check("R8 nested mask", cur_mask, 0);

    irq_in = '0;
    wr(34, 10);
    check("R7 mismatched eos ignored id", svc_id, 7);
    check("R7 mismatched eos ignored mask", cur_mask, 0);
    wr(34, 7);
    check("R7 pop restores mask", cur_mask, 2);
    check("R8 outer entry visible", svc_id, 10);
    wr(34, 10);
    check("R7 second pop mask", cur_mask, 3);
    check("R8 stack empty", svc_active, 0);

    // Break path
    ie = 0; wr(32, 0);
    brk_n = 0;
    tick(2);
    check("R9 break not before sync", brk_req, 0);
    tick(1);
    check("R9 break after third edge", brk_req, 1);
    tick(5);
    check("R10 break sticky", brk_req, 1);
    brk_ack = 1; tick(1); brk_ack = 0;
    check("R10 break cleared by ack", brk_req, 0);
    tick(5);
    check("R10 held low no retrigger", brk_req, 0);
    brk_n = 1;
    tick(4);
    check("R10 rising edge ignored", brk_req, 0);

    // Mixed traffic against the model
    ie = 1; wr(32, 7);
    for (int c = 0; c < 600; c++) begin
      irq_in  = $urandom & $urandom;
      ie      = ($urandom % 8) != 0;
      ack     = ($urandom % 4) == 0;
      brk_ack = ($urandom % 16) == 0;
      if (($urandom % 23) == 0) brk_n = ~brk_n;
      case ($urandom % 6)
        0: begin reg_we = 1; reg_addr = 6'($urandom % 32); reg_wdata = 32'($urandom % 8); end
        1: begin reg_we = 1; reg_addr = 6'd34; reg_wdata = 32'(svc_id); end
        2: begin reg_we = 1; reg_addr = 6'd34; reg_wdata = 32'($urandom % 32); end
        3: begin reg_we = ($urandom % 4) == 0; reg_addr = 6'd32; reg_wdata = 32'($urandom % 8); end
        default: reg_we = 0;
      endcase
      tick(1);
    end
    reg_we = 0; ack = 0; brk_ack = 0;
    tick(2);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule